// File: doc/BRIEF.md
# Dual-Select Static RAM Emulator

This block is a clock-sampled model of an asynchronous byte-wide static RAM with two chip selects. One select is active low and one is active high, and the device counts as selected only when both are asserted. A fast system clock samples both selects, the active-low write strobe, the active-low output enable, the address and the incoming data byte. The block then acts on those samples. The storage is an internal register file.

A write lasts as long as three conditions hold together: the low select is asserted, the high select is asserted, and the write strobe is low. Whichever of the three drops first closes the window. The block then commits the byte and address that it sampled on the last clock of the window. A value that appears on the bus in the same sample that closes the window is not stored.

Reads drive data through a separate data-out bus with an output-enable flag, so a bidirectional pad can be built outside the block. A power-down flag reports deselection.

The design centres on a four-state machine:
- **SLEEP**: deselected.
- **IDLE**: selected, with neither read nor write.
- **READ**: selected, output enabled, write strobe high.
- **WRITE**: the overlap window.

Every state is entered directly from any other state. The sampled inputs decide, in priority order:
1. deselect leads to SLEEP;
2. write strobe low leads to WRITE;
3. output enable low leads to READ;
4. otherwise IDLE.

Leaving WRITE for any other state is the commit transition.

Top module: `sram_emu`

## Requirements
- R1: The array holds 2^ADDR_W words of DATA_W bits (ADDR_W=13 gives 8192 bytes; the default is 10). Every address is written and read back independently.
- R2: A write is stored only if the sampled overlap held: `sel_n`=0, `sel`=1 and `wr_n`=0. With `wr_n` low while either select is inactive, memory is unchanged.
- R3: Each of the following closes the window and commits the write: `wr_n` rising, `sel_n` rising, or `sel` falling.
- R4: The stored byte is the `din` value sampled on the last clock of the window. A `din` change applied together with the terminating edge is not stored.
- R5: If `addr` changes during a window, the address sampled on the last clock of the window is written, and earlier addresses are untouched.
- R6: With `sel_n`=0, `sel`=1, `rd_n`=0 and `wr_n`=1 applied before clock edge k, `dout_en`=1 and `dout` holds the addressed word after edge k+1.
- R7: `dout_en` is 0 whenever the read condition is absent, including while `wr_n` is low with the output enabled.
- R8: `pwr_down` is 1 after edge k+1 when either select is inactive before edge k, and 0 after edge k+1 after reselect. After reset, `pwr_down`=1 and `dout_en`=0.
- R9: A read of the address whose write commits at the same edge returns the new byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | sampling clock |
| rst | input | 1 | synchronous reset, active high |
| sel_n | input | 1 | active-low chip select |
| sel | input | 1 | active-high chip select |
| wr_n | input | 1 | active-low write strobe |
| rd_n | input | 1 | active-low output enable |
| addr | input | ADDR_W | word address |
| din | input | DATA_W | data bus value seen by the pads |
| dout | output | DATA_W | read data |
| dout_en | output | 1 | drive enable for the data pads |
| pwr_down | output | 1 | deselected / power-down flag |

## Verification
If the machine is stuck in the wrong state, `dout_en` or `pwr_down` disagrees with the controls two clocks after they are applied. A wrongly captured window byte or address stays hidden until that location is read back. For that reason, the bench writes every address with a byte computed from the address, using a rotating terminator, and then reads every address. Timing-sensitive corners are sampled on the exact clock where they first become visible: the hold edge, an address moved mid-window, and a read that collides with a commit.

// File: rtl/sram_emu_pkg.sv
package sram_emu_pkg;

    typedef enum logic [1:0] {
        ST_SLEEP = 2'd0,
        ST_IDLE  = 2'd1,
        ST_READ  = 2'd2,
        ST_WRITE = 2'd3
    } emu_state_t;

    typedef struct packed {
        logic sel_n;
        logic sel;
        logic wr_n;
        logic rd_n;
    } ctl_smp_t;

endpackage

// File: rtl/sram_emu_sampler.sv
module sram_emu_sampler
    import sram_emu_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_n,
    input  logic              sel,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output ctl_smp_t          ctl_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] din_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= '{sel_n: 1'b1, sel: 1'b0, wr_n: 1'b1, rd_n: 1'b1};
            addr_q <= '0;
            din_q  <= '0;
        end else begin
            ctl_q  <= '{sel_n: sel_n, sel: sel, wr_n: wr_n, rd_n: rd_n};
            addr_q <= addr;
            din_q  <= din;
        end
    end

endmodule

// File: rtl/sram_emu_fsm.sv
module sram_emu_fsm
    import sram_emu_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  ctl_smp_t          ctl_q,
    input  logic [ADDR_W-1:0] addr_q,
    input  logic [DATA_W-1:0] din_q,
    output logic              commit,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              drive,
    output logic              pwr_down
);

    emu_state_t state, nxt;
    logic       selected;

    assign selected = !ctl_q.sel_n && ctl_q.sel;

    // Next-state choice: deselect wins, then write, then read.
    always_comb begin
        if (!selected)       nxt = ST_SLEEP;
        else if (!ctl_q.wr_n) nxt = ST_WRITE;
        else if (!ctl_q.rd_n) nxt = ST_READ;
        else                  nxt = ST_IDLE;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) state <= ST_SLEEP;
        else     state <= nxt;
    end

    // Latest in-window address and byte; the final sample is what commits.
    always_ff @(posedge clk) begin
        if (rst) begin
            wr_addr <= '0;
            wr_data <= '0;
        end else if (nxt == ST_WRITE) begin
            wr_addr <= addr_q;
            wr_data <= din_q;
        end
    end

    // Outputs decoded from the current state.
    always_comb begin
        commit   = 1'b0;
        drive    = 1'b0;
        pwr_down = 1'b0;
        unique case (state)
            ST_SLEEP: pwr_down = 1'b1;
            ST_IDLE:  ;
            ST_READ:  drive = 1'b1;
            ST_WRITE: commit = (nxt != ST_WRITE);
        endcase
    end

    // R2: a commit needs the full overlap in the preceding sample.
    p_commit_needs_overlap_r2: assert property (@(posedge clk) disable iff (rst)
        commit |-> $past(!ctl_q.sel_n && ctl_q.sel && !ctl_q.wr_n));

    // R8: a deselected sample raises the flag one edge later.
    p_desel_sets_flag_r8: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.sel_n || !ctl_q.sel) |=> pwr_down);

    // R7: a low write strobe keeps the bus released.
    p_no_drive_in_write_r7: assert property (@(posedge clk) disable iff (rst)
        !ctl_q.wr_n |=> !drive);

    // R6: driving requires output enable low and write strobe high in the prior sample.
    p_drive_needs_read_r6: assert property (@(posedge clk) disable iff (rst)
        drive |-> $past(!ctl_q.rd_n && ctl_q.wr_n && selected));

endmodule

// File: rtl/sram_emu_store.sv
module sram_emu_store #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/sram_emu.sv
module sram_emu
    import sram_emu_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_n,
    input  logic              sel,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en,
    output logic              pwr_down
);

    ctl_smp_t          ctl_q;
    logic [ADDR_W-1:0] addr_q, wr_addr;
    logic [DATA_W-1:0] din_q, wr_data, rd_word;
    logic              commit;

    sram_emu_sampler #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_smp (
        .clk(clk), .rst(rst), .sel_n(sel_n), .sel(sel), .wr_n(wr_n), .rd_n(rd_n),
        .addr(addr), .din(din), .ctl_q(ctl_q), .addr_q(addr_q), .din_q(din_q)
    );

    sram_emu_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst(rst), .ctl_q(ctl_q), .addr_q(addr_q), .din_q(din_q),
        .commit(commit), .wr_addr(wr_addr), .wr_data(wr_data),
        .drive(dout_en), .pwr_down(pwr_down)
    );

    sram_emu_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk(clk), .we(commit), .waddr(wr_addr), .wdata(wr_data),
        .raddr(addr_q), .rdata(rd_word)
    );

    // Read register with forwarding of a commit landing on the same edge (R9).
    always_ff @(posedge clk) begin
        if (rst)                                dout <= '0;
        else if (commit && (wr_addr == addr_q)) dout <= wr_data;
        else                                    dout <= rd_word;
    end

    // R9: a colliding commit forwards its byte to the read register.
    p_forward_on_collide_r9: assert property (@(posedge clk) disable iff (rst)
        (commit && (wr_addr == addr_q)) |=> (dout == $past(wr_data)));

endmodule

// File: tb/tb_sram_emu.sv
module tb_sram_emu;

    localparam int AW    = 10;
    localparam int DW    = 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst;
    logic          sel_n, sel, wr_n, rd_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] din;
    logic [DW-1:0] dout;
    logic          dout_en, pwr_down;

    int n_vec  = 0;
    int n_miss = 0;
    bit done   = 1'b0;

    logic [DW-1:0] model [DEPTH];

    always #5 clk = ~clk;

    sram_emu #(.ADDR_W(AW), .DATA_W(DW)) dut (
        .clk(clk), .rst(rst), .sel_n(sel_n), .sel(sel), .wr_n(wr_n), .rd_n(rd_n),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en), .pwr_down(pwr_down)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int got, input int exp);
        n_vec++;
        if (got != exp) begin
            n_miss++;
            $display("FAIL %s got=%0h expected=%0h", req, got, exp);
        end
    endtask

    function automatic logic [DW-1:0] pat(input int a);
        return DW'((a * 37 + 5) & 8'hFF);
    endfunction

    // term: 0 write strobe rises, 1 low select rises, 2 high select falls
    task automatic do_write(input int a, input logic [DW-1:0] d, input int term);
        addr = AW'(a); din = d; sel_n = 1'b0; sel = 1'b1; rd_n = 1'b1; wr_n = 1'b0;
        tick(2);
        case (term)
            0:       wr_n  = 1'b1;
            1:       sel_n = 1'b1;
            default: sel   = 1'b0;
        endcase
        tick(1);
        sel_n = 1'b0; sel = 1'b1; wr_n = 1'b1;
        tick(2);
        model[a] = d;
    endtask

    task automatic do_read(input int a, input string req);
        addr = AW'(a); sel_n = 1'b0; sel = 1'b1; wr_n = 1'b1; rd_n = 1'b0;
        tick(2);
        check(req, int'(dout_en), 1);
        check(req, int'(dout), int'(model[a]));
        rd_n = 1'b1;
    endtask

    initial begin
        #(2_000_000);
        if (!done) begin
            n_miss++;
            $display("FAIL watchdog got=hang expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; sel_n = 1'b1; sel = 1'b0; wr_n = 1'b1; rd_n = 1'b1;
        addr = '0; din = '0;
        tick(3);
        // R8 reset state
        check("R8 reset pwr_down", int'(pwr_down), 1);
        check("R8 reset dout_en", int'(dout_en), 0);
        rst = 1'b0;
        tick(2);

        // R1 R3 sweep: every address, terminator rotated
        for (int a = 0; a < DEPTH; a++) do_write(a, pat(a), a % 3);
        for (int a = 0; a < DEPTH; a++) begin
            do_read(a, "R1 sweep");
            check("R3 term", int'(dout), int'(pat(a)));
        end

        // R2: write strobe low while deselected, by each select
        addr = AW'(5); din = 8'h3C; sel_n = 1'b1; sel = 1'b1; wr_n = 1'b0; tick(3);
        sel_n = 1'b0; sel = 1'b0; tick(3);
        wr_n = 1'b1; sel = 1'b1; tick(2);
        do_read(5, "R2 no write when deselected");

        // R4: data changed with the terminating edge is not stored
        addr = AW'(7); din = 8'hAA; sel_n = 1'b0; sel = 1'b1; rd_n = 1'b1; wr_n = 1'b0;
        tick(2);
        wr_n = 1'b1; din = 8'h55;
        tick(3);
        model[7] = 8'hAA;
        do_read(7, "R4 hold edge");

        // R5: address moved mid-window
        addr = AW'(8); din = 8'h11; wr_n = 1'b0; tick(1);
        addr = AW'(9); tick(2);
        wr_n = 1'b1; tick(3);
        model[9] = 8'h11;
        do_read(8, "R5 first address untouched");
        do_read(9, "R5 final address written");

        // R7: output enable low with write strobe low, and output enable high
        addr = AW'(9); din = 8'h11; rd_n = 1'b0; wr_n = 1'b0; tick(2);
        check("R7 released in write", int'(dout_en), 0);
        wr_n = 1'b1; rd_n = 1'b1; tick(2);
        check("R7 released when rd_n high", int'(dout_en), 0);

        // R8 latency on deselect and reselect
        sel_n = 1'b1; tick(1);
        check("R8 not yet down", int'(pwr_down), 0);
        tick(1);
        check("R8 down", int'(pwr_down), 1);
        sel_n = 1'b0; tick(1);
        check("R8 not yet up", int'(pwr_down), 1);
        tick(1);
        check("R8 up", int'(pwr_down), 0);
        sel = 1'b0; tick(2);
        check("R8 down by high select", int'(pwr_down), 1);
        sel = 1'b1; tick(2);

        // R6 exact latency
        addr = AW'(20); rd_n = 1'b0; tick(1);
        check("R6 not yet driven", int'(dout_en), 0);
        tick(1);
        check("R6 driven", int'(dout_en), 1);
        check("R6 data", int'(dout), int'(pat(20)));
        rd_n = 1'b1; tick(1);

        // R9: read of the address whose write commits on the same edge
        addr = AW'(3); din = 8'hE7; wr_n = 1'b0; tick(2);
        wr_n = 1'b1; rd_n = 1'b0; tick(2);
        check("R9 forward en", int'(dout_en), 1);
        check("R9 forward data", int'(dout), 'hE7);
        model[3] = 8'hE7;
        rd_n = 1'b1; tick(1);
        do_read(3, "R9 stored");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
        $finish;
    end

endmodule